// File: doc/BRIEF.md
# Eight-Queue Egress Scheduler

This block decides which of eight class-of-service queues on one egress port transmits next. For every queue it sees a nonempty flag and the byte length of the packet at the head of that queue. Each time the transmitter pulses its ready strobe, the block answers with at most one grant naming a queue. The answer appears in the clock cycle after the strobe.

A two-bit mode input selects the discipline. Strict priority always serves the highest-numbered nonempty queue. Packet-weighted round robin lets each queue send up to its weight in packets per round. Byte-deficit round robin credits each queue with its weight times 10240 bytes per round and charges it the length of every packet it sends. Each queue has a 4-bit weight. In the two weighted modes, a weight of zero takes the queue out of the rounds and serves it ahead of all weighted queues, as strict priority.

Top module: `egress_cos_sched`

## Requirements
- R1: `cfg_mode` encodes 0 = strict, 1 = weighted round robin (WRR), 2 = deficit round robin (DRR), and 3 behaves as strict. A `tx_ready` high at a clock edge produces, in the next cycle only, `grant_valid` high with `grant_idx` naming a queue that was nonempty at that edge. No grant appears without `tx_ready` or when no queue is nonempty.
- R2: In strict mode the grant goes to the highest-index nonempty queue (queue 7 ranks highest). Weights have no effect, and the same queue is served for as long as it stays nonempty.
- R3: In WRR and DRR, nonempty queues of weight 0 are granted before any weighted queue, highest index first. They use no allowance.
- R4: In WRR, a queue of weight w (field `cfg_weight[4*i+3:4*i]`) sends at most w packets per round. The search continues from the last served queue in ascending circular order, so a queue is served back to back until its allowance is spent. When no nonempty weighted queue has allowance left, a new round reloads every allowance to its weight and the search starts from queue 0, granting in the same cycle.
- R5: In WRR, a queue that goes empty keeps its unused allowance for the rest of the round.
- R6: In DRR, a new round adds weight × 10240 bytes to the deficit of each nonempty weighted queue, and the search starts from queue 0. A queue is granted only when its deficit is at least its head length (`q_len[14*i+13:14*i]`). The granted length is subtracted from the deficit. Otherwise the ascending circular search order is the same as in R4.
- R7: In DRR, if even the new round's credit does not cover any head packet, the strobe gets no grant and the credit is kept for the next strobe.
- R8: In DRR, the deficit of a queue that is empty at a clock edge is cleared to zero.
- R9: In the cycle where `cfg_mode` differs from its value at the previous edge, no grant is issued. All allowances, deficits and the round position are cleared.
- R10: After synchronous reset, `grant_valid` and `grant_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | Scheduling discipline |
| cfg_weight | input | 32 | Four-bit weight per queue, queue i at bits 4i+3..4i |
| q_nonempty | input | 8 | Queue i holds at least one packet |
| q_len | input | 112 | Head packet byte length per queue, queue i at bits 14i+13..14i |
| tx_ready | input | 1 | Transmitter requests one grant |
| grant_idx | output | 3 | Granted queue |
| grant_valid | output | 1 | One-cycle grant pulse |

## Verification
Strict mode is tried with two competing queues, then one, then none. This separates highest-index selection from mere presence, and it shows that weights and the spare mode code do not change the choice. The weighted modes are driven with uneven weights and with zero-weight queues mixed into busy rounds, which exposes a wrong order within a round, a missing consecutive service, and a wrong rank for zero-weight queues. Further patterns make a queue empty in the middle of a round, send DRR head packets larger than one round's credit, and switch modes halfway through a round. These cases tell apart allowance that is kept, allowance that is cleared, and credit that carries into the next round, because each choice leads to a different later grant sequence.

// File: rtl/egress_sched_pkg.sv
// Shared definitions for the egress scheduler.
// Assumes a two-bit mode field; the spare code is treated as strict priority.
package egress_sched_pkg;
    typedef enum logic [1:0] {
        MODE_STRICT = 2'd0,
        MODE_WRR    = 2'd1,
        MODE_DRR    = 2'd2
    } sched_mode_e;
endpackage

// File: rtl/sched_prio_pick.sv
// Picks the highest-index set request.
// Assumes N >= 2; idx is 0 when no request is set.
module sched_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan upward so the last set bit found wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k]) begin
                hit = 1'b1;
                idx = IW'(k);
            end
        end
    end
endmodule

// File: rtl/sched_rr_pick.sv
// Picks the first set request at or after start, wrapping around.
// Assumes N is a power of two, so the index arithmetic wraps by itself.
module sched_rr_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] probe;

    // Circular scan from start; the first hit is kept.
    always_comb begin
        hit   = 1'b0;
        idx   = start;
        probe = start;
        for (int k = 0; k < N; k++) begin
            probe = start + IW'(k);
            if (!hit && req[probe]) begin
                hit = 1'b1;
                idx = probe;
            end
        end
    end
endmodule

// File: rtl/sched_lane.sv
// Allowance register of one queue: a packet count in WRR and a byte deficit in DRR.
// Reports whether the queue can send now with its current allowance, or after a
// new round's credit. Assumes the top raises take only for an eligible queue.
module sched_lane #(
    parameter int LW    = 14,
    parameter int WW    = 4,
    parameter int CHUNK = 10240
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drr,
    input  logic          ne,
    input  logic [WW-1:0] wgt,
    input  logic [LW-1:0] len,
    input  logic          clr,
    input  logic          new_round,
    input  logic          take,
    output logic          elig,
    output logic          fresh_elig
);
    localparam int DW   = $clog2((2**LW) + (2**WW - 1) * CHUNK) + 1;
    localparam int WMAX = 2**WW - 1;

    logic [DW-1:0] alw;
    logic [DW-1:0] cost;
    logic [DW-1:0] quantum;
    logic [DW-1:0] fresh;
    logic          active;

    // Price of the head packet, round credit, and the allowance after a new round.
    always_comb begin
        cost       = drr ? DW'(len) : DW'(1);
        quantum    = drr ? DW'(wgt) * DW'(CHUNK) : DW'(wgt);
        fresh      = drr ? (ne ? alw + quantum : '0) : quantum;
        active     = ne && (wgt != '0);
        elig       = active && (alw >= cost);
        fresh_elig = active && (fresh >= cost);
    end

    // Allowance update: clear, empty flush (DRR only), round reload, or charge.
    always_ff @(posedge clk) begin
        if (!rst_n)           alw <= '0;
        else if (clr)         alw <= '0;
        else if (drr && !ne)  alw <= '0;
        else if (new_round)   alw <= take ? fresh - cost : fresh;
        else if (take)        alw <= alw - cost;
    end

    // R4: a packet count can never exceed the largest weight.
    a_r4_wrr_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!drr && !clr) |-> (alw <= DW'(WMAX)));
endmodule

// File: rtl/egress_cos_sched.sv
// Egress scheduler for NQ class-of-service queues with strict priority,
// packet-weighted round robin and byte-deficit round robin.
// Assumes NQ is a power of two. Issues one registered grant per tx_ready strobe.
module egress_cos_sched
    import egress_sched_pkg::*;
#(
    parameter int NQ    = 8,
    parameter int WW    = 4,
    parameter int LW    = 14,
    parameter int CHUNK = 10240
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_mode,
    input  logic [NQ*WW-1:0]     cfg_weight,
    input  logic [NQ-1:0]        q_nonempty,
    input  logic [NQ*LW-1:0]     q_len,
    input  logic                 tx_ready,
    output logic [$clog2(NQ)-1:0] grant_idx,
    output logic                 grant_valid
);
    localparam int IW = $clog2(NQ);

    logic [1:0]    mode_q;
    logic [IW-1:0] ptr, ptr_n;
    logic          mode_chg, weighted, drr;
    logic [NQ-1:0] wzero, elig, fresh_elig, take;
    logic [NQ-1:0] hp_req;
    logic          hp_hit, b_hit, c_hit;
    logic [IW-1:0] hp_idx, b_idx, c_idx;
    logic          new_round, gv_n;
    logic [IW-1:0] gi_n;

    // Mode decode and change detection.
    always_comb begin
        mode_chg = (cfg_mode != mode_q);
        drr      = (cfg_mode == MODE_DRR);
        weighted = (cfg_mode == MODE_WRR) || drr;
        hp_req   = weighted ? (q_nonempty & wzero) : q_nonempty;
    end

    for (genvar i = 0; i < NQ; i++) begin : g_lane
        assign wzero[i] = (cfg_weight[i*WW +: WW] == '0);
        sched_lane #(.LW(LW), .WW(WW), .CHUNK(CHUNK)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .drr        (drr),
            .ne         (q_nonempty[i]),
            .wgt        (cfg_weight[i*WW +: WW]),
            .len        (q_len[i*LW +: LW]),
            .clr        (mode_chg),
            .new_round  (new_round),
            .take       (take[i]),
            .elig       (elig[i]),
            .fresh_elig (fresh_elig[i])
        );
    end

    sched_prio_pick #(.N(NQ)) u_hp (.req(hp_req), .hit(hp_hit), .idx(hp_idx));
    sched_rr_pick   #(.N(NQ)) u_cur (.req(elig), .start(ptr), .hit(b_hit), .idx(b_idx));
    sched_rr_pick   #(.N(NQ)) u_new (.req(fresh_elig), .start('0), .hit(c_hit), .idx(c_idx));

    // Grant decision: strict-ranked queues, then current round, then a new round.
    always_comb begin
        take      = '0;
        new_round = 1'b0;
        gv_n      = 1'b0;
        gi_n      = '0;
        ptr_n     = ptr;
        if (tx_ready && !mode_chg) begin
            if (hp_hit) begin
                gv_n = 1'b1;
                gi_n = hp_idx;
            end else if (weighted) begin
                if (b_hit) begin
                    gv_n        = 1'b1;
                    gi_n        = b_idx;
                    take[b_idx] = 1'b1;
                    ptr_n       = b_idx;
                end else if ((q_nonempty & ~wzero) != '0) begin
                    new_round = 1'b1;
                    ptr_n     = c_hit ? c_idx : '0;
                    if (c_hit) begin
                        gv_n        = 1'b1;
                        gi_n        = c_idx;
                        take[c_idx] = 1'b1;
                    end
                end
            end
        end
    end

    // Registered grant, round position and remembered mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
            ptr         <= '0;
            mode_q      <= MODE_STRICT;
        end else begin
            grant_valid <= gv_n;
            if (gv_n) grant_idx <= gi_n;
            ptr         <= mode_chg ? '0 : ptr_n;
            mode_q      <= cfg_mode;
        end
    end

    // R1: every grant answers a strobe.
    a_r1_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(tx_ready));
    // R1: the granted queue was nonempty at the strobe.
    a_r1_grant_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((($past(q_nonempty) >> grant_idx) & NQ'(1)) != '0));
    // R2: in strict mode no higher-index queue was waiting.
    a_r2_strict_top: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && ($past(cfg_mode) != MODE_WRR) && ($past(cfg_mode) != MODE_DRR))
        |-> (($past(q_nonempty) >> grant_idx) == NQ'(1)));
    // R9: a mode switch suppresses the grant of that cycle.
    a_r9_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode) != $past(mode_q)) |-> !grant_valid);
endmodule

// File: tb/sim_egress_cos_sched.sv
`timescale 1ns/1ps
module sim_egress_cos_sched;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_ready = 1'b0;
    logic [1:0]   cfg_mode = 2'd0;
    logic [31:0]  cfg_weight = '0;
    logic [7:0]   q_nonempty = '0;
    logic [111:0] q_len = '0;
    logic [2:0]   grant_idx;
    logic         grant_valid;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    egress_cos_sched u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_weight(cfg_weight),
        .q_nonempty(q_nonempty), .q_len(q_len), .tx_ready(tx_ready),
        .grant_idx(grant_idx), .grant_valid(grant_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One ready pulse; the grant is sampled at the following falling edge.
    task automatic strobe(input string req, input bit exp_v, input int exp_i);
        @(negedge clk) tx_ready = 1'b1;
        @(negedge clk) tx_ready = 1'b0;
        chk({req, " valid"}, grant_valid, exp_v);
        if (exp_v) chk({req, " index"}, grant_idx, exp_i);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) cfg_mode = m;
        @(negedge clk);
    endtask

    task automatic set_w(input int q, input int w);
        cfg_weight[q*4 +: 4] = 4'(w);
    endtask

    task automatic set_len(input int q, input int l);
        q_len[q*14 +: 14] = 14'(l);
    endtask

    task automatic fresh_start(input logic [1:0] m);
        cfg_weight = '0; q_nonempty = '0; q_len = '0;
        set_mode(2'd0);
        set_mode(m);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 valid", grant_valid, 0);
        chk("R10 index", grant_idx, 0);
    endtask

    task automatic t_strict();
        fresh_start(2'd0);
        set_w(1, 5); set_w(4, 2);
        q_nonempty = 8'b0001_0010;
        strobe("R2", 1, 4);
        strobe("R2", 1, 4);
        @(negedge clk);
        chk("R1 no ready", grant_valid, 0);
        q_nonempty = 8'b0000_0010;
        strobe("R2", 1, 1);
        q_nonempty = '0;
        strobe("R1 none", 0, 0);
        set_mode(2'd3);
        q_nonempty = 8'b0001_0010;
        strobe("R1 spare mode", 1, 4);
    endtask

    task automatic t_wrr();
        fresh_start(2'd1);
        set_w(0, 2); set_w(1, 1); set_w(2, 3);
        q_nonempty = 8'b0000_0111;
        strobe("R4", 1, 0); strobe("R4", 1, 0); strobe("R4", 1, 1);
        strobe("R4", 1, 2); strobe("R4", 1, 2); strobe("R4", 1, 2);
        strobe("R4", 1, 0); strobe("R4", 1, 0); strobe("R4", 1, 1);
    endtask

    task automatic t_zero();
        fresh_start(2'd1);
        set_w(2, 3);
        q_nonempty = 8'b0110_0100;
        strobe("R3", 1, 6); strobe("R3", 1, 6);
        q_nonempty = 8'b0010_0100;
        strobe("R3", 1, 5);
        q_nonempty = 8'b0000_0100;
        strobe("R3", 1, 2);
    endtask

    task automatic t_skip();
        fresh_start(2'd1);
        set_w(0, 3); set_w(1, 1);
        q_nonempty = 8'b0000_0011;
        strobe("R5", 1, 0);
        q_nonempty = 8'b0000_0010;
        strobe("R5", 1, 1);
        q_nonempty = 8'b0000_0011;
        strobe("R5", 1, 0); strobe("R5", 1, 0); strobe("R5", 1, 0);
        strobe("R5", 1, 0); strobe("R5", 1, 0); strobe("R5", 1, 1);
    endtask

    task automatic t_mode();
        fresh_start(2'd1);
        set_w(0, 2); set_w(1, 2);
        q_nonempty = 8'b0000_0011;
        strobe("R9", 1, 0);
        @(negedge clk) begin cfg_mode = 2'd2; tx_ready = 1'b1; end
        @(negedge clk) tx_ready = 1'b0;
        chk("R9 switch cycle", grant_valid, 0);
        set_mode(2'd1);
        strobe("R9", 1, 0); strobe("R9", 1, 0); strobe("R9", 1, 1);
    endtask

    task automatic t_drr();
        fresh_start(2'd2);
        set_w(1, 1); set_w(3, 2);
        set_len(1, 6000); set_len(3, 12000);
        q_nonempty = 8'b0000_1010;
        strobe("R6", 1, 1); strobe("R6", 1, 3); strobe("R6", 1, 1);
        strobe("R6", 1, 1); strobe("R6", 1, 3); strobe("R6", 1, 3);
        strobe("R6", 1, 1);
    endtask

    task automatic t_big();
        fresh_start(2'd2);
        set_w(2, 1); set_len(2, 15000);
        q_nonempty = 8'b0000_0100;
        strobe("R7 short credit", 0, 0);
        strobe("R7 carried credit", 1, 2);
    endtask

    task automatic t_flush();
        fresh_start(2'd2);
        set_w(1, 1); set_w(3, 1);
        set_len(1, 6000); set_len(3, 6000);
        q_nonempty = 8'b0000_1010;
        strobe("R8", 1, 1); strobe("R8", 1, 3);
        q_nonempty = 8'b0000_1000;
        @(negedge clk);
        q_nonempty = 8'b0000_1010;
        strobe("R8", 1, 1); strobe("R8", 1, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_strict();
        t_wrr();
        t_zero();
        t_skip();
        t_mode();
        t_drr();
        t_big();
        t_flush();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule